// File: doc/BRIEF.md
# Protected Serial-In Parallel-Out Channel Driver Core

This block is the digital control core of a multi-channel low-side driver that is loaded serially and protects itself against faults. A serial bit stream is shifted into a chain of stages on each rising edge of a slow serial clock. The last stage is presented as serial data out, so several blocks can be chained. A strobe copies the chain into a bank of output latches. The latches are transparent while the strobe is high and hold while it is low. An active-low enable gates the channel drive signals without touching the stored data.

Each channel has its own over-current input. A per-channel filter counts system clock cycles and ignores short pulses. A condition that lasts long enough shuts only that channel off and latches the fault. The shared active-low fault flag stays low until the enable input is taken high or the block is reset. A thermal input forces every channel off and pulls the flag low, but it is not latched. An undervoltage input acts like the enable held high: channels are off and latched faults are cleared. The serial clock, serial data, strobe, clear and enable pins pass through synchronisers into one system clock domain. The rising edge of the serial clock is detected in that domain.

Top module: `prot_sipo_driver`

## Requirements
- R1: On each rising edge of `ser_clk_i`, the value on `ser_din_i` enters stage 0, every stage moves one place toward the last stage, and `ser_dout_o` shows the last stage (index NUM_CH-1). After NUM_CH shifts, the bit shifted first sits in the last stage.
- R2: While `clear_i` is high, each serial clock edge shifts in a 0 whatever `ser_din_i` holds. The cleared contents reach `drive_o` only after a strobe.
- R3: While `strobe_i` is high, latch bit i copies stage i. While it is low, the latches hold, so shifting does not change `drive_o`. Channel i (`drive_o[i]`) follows latch bit i.
- R4: While `oe_n_i` is high, every `drive_o` bit is 0. Taking it low again restores the latched pattern unchanged.
- R5: An over-current input held high for fewer than FILT_CYCLES consecutive system clock cycles has no effect. Dropping it restarts the count.
- R6: An over-current input held high for FILT_CYCLES consecutive cycles, while its channel is driven, turns off only that channel and drives `flag_n_o` low.
- R7: A tripped channel and the low flag stay latched after the over-current input drops. They clear only when `oe_n_i` is taken high, or on reset.
- R8: While `therm_i` is high, all channels are off and `flag_n_o` is low. Both recover on the first cycle after it drops, with no enable pulse.
- R9: While `uv_i` is high, all channels are off and latched over-current faults are cleared.
- R10: An over-current input on a channel that is not being driven never trips that channel.
- R11: After synchronous reset, the chain, latches and faults are cleared: `drive_o` is 0, `ser_dout_o` is 0 and `flag_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial shift clock, rising edge active |
| ser_din_i | input | 1 | Serial data in |
| strobe_i | input | 1 | Latch transparent while high |
| clear_i | input | 1 | Shift zeros while high |
| oe_n_i | input | 1 | Output enable, active low; high also resets faults |
| ocp_i | input | NUM_CH | Per-channel over-current sense |
| therm_i | input | 1 | Thermal over-limit, active high |
| uv_i | input | 1 | Undervoltage, active high |
| ser_dout_o | output | 1 | Last stage of the shift chain |
| drive_o | output | NUM_CH | Channel drive, 1 = on |
| flag_n_o | output | 1 | Fault flag, active low |

## Verification
A wrong stage in the shift chain shows at `ser_dout_o` within NUM_CH serial clocks, and at `drive_o` on the next strobe. A latch that leaks while the strobe is low changes `drive_o` within a few system cycles of a shift, before any strobe. A filter count that is off by one moves the trip by one cycle, so the bench steps the over-current duration to exactly FILT_CYCLES-1 and FILT_CYCLES cycles on every channel. A stuck or cleared fault latch shows at once on the channel's drive bit and on `flag_n_o`.

// File: rtl/psd_pkg.sv
package psd_pkg;

   typedef enum logic [1:0] {
      OCP_IDLE    = 2'd0,
      OCP_FILTER  = 2'd1,
      OCP_TRIPPED = 2'd2
   } ocp_state_e;

   localparam int unsigned SYNC_BUNDLE_W = 5;
   localparam int unsigned SB_SCLK   = 0;
   localparam int unsigned SB_DIN    = 1;
   localparam int unsigned SB_STROBE = 2;
   localparam int unsigned SB_CLEAR  = 3;
   localparam int unsigned SB_OEN    = 4;

endpackage

// File: rtl/psd_sync.sv
module psd_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("psd_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("psd_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= RST_VAL;
            else     chain[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= RST_VAL;
            else     chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/psd_shift_latch.sv
module psd_shift_latch #(
   parameter int unsigned NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sclk_s,
   input  logic              din_s,
   input  logic              clear_s,
   input  logic              strobe_s,
   output logic              shift_rise,
   output logic [NUM_CH-1:0] sreg,
   output logic [NUM_CH-1:0] latch_q
);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("psd_shift_latch: NUM_CH must be at least 2");
   end

   logic sclk_prev;
   logic shift_bit;

   always_ff @(posedge clk) begin
      if (rst) sclk_prev <= 1'b0;
      else     sclk_prev <= sclk_s;
   end

   assign shift_rise = sclk_s & ~sclk_prev;
   assign shift_bit  = clear_s ? 1'b0 : din_s;

   always_ff @(posedge clk) begin
      if (rst) begin
         sreg <= '0;
      end else if (shift_rise) begin
         sreg <= {sreg[NUM_CH-2:0], shift_bit};
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_latch
      always_ff @(posedge clk) begin
         if (rst)           latch_q[i] <= 1'b0;
         else if (strobe_s) latch_q[i] <= sreg[i];
      end
   end

endmodule

// File: rtl/psd_ocp_chan.sv
module psd_ocp_chan
   import psd_pkg::*;
#(
   parameter int unsigned FILT_CYCLES = 500
) (
   input  logic clk,
   input  logic rst,
   input  logic ocp_i,
   input  logic drv_req,
   input  logic fault_clr,
   output logic fault_o
);

   if (FILT_CYCLES < 2) begin : g_bad_filt
      $error("psd_ocp_chan: FILT_CYCLES must be at least 2");
   end

   localparam int unsigned CW = $clog2(FILT_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

   ocp_state_e    state;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= OCP_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            OCP_IDLE: begin
               cnt <= '0;
               if (!fault_clr && ocp_i && drv_req) begin
                  state <= OCP_FILTER;
                  cnt   <= CW'(1);
               end
            end
            OCP_FILTER: begin
               if (fault_clr || !ocp_i || !drv_req) begin
                  state <= OCP_IDLE;
                  cnt   <= '0;
               end else if (cnt == LAST) begin
                  state <= OCP_TRIPPED;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            OCP_TRIPPED: begin
               cnt <= '0;
               if (fault_clr) state <= OCP_IDLE;
            end
            default: begin
               state <= OCP_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign fault_o = (state == OCP_TRIPPED);

endmodule

// File: rtl/prot_sipo_driver.sv
module prot_sipo_driver
   import psd_pkg::*;
#(
   parameter int unsigned NUM_CH      = 8,
   parameter int unsigned FILT_CYCLES = 500,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ser_clk_i,
   input  logic              ser_din_i,
   input  logic              strobe_i,
   input  logic              clear_i,
   input  logic              oe_n_i,
   input  logic [NUM_CH-1:0] ocp_i,
   input  logic              therm_i,
   input  logic              uv_i,
   output logic              ser_dout_o,
   output logic [NUM_CH-1:0] drive_o,
   output logic              flag_n_o
);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("prot_sipo_driver: NUM_CH must be at least 2");
   end

   localparam logic [SYNC_BUNDLE_W-1:0] SYNC_RST = SYNC_BUNDLE_W'(1) << SB_OEN;

   logic [SYNC_BUNDLE_W-1:0] pins_raw;
   logic [SYNC_BUNDLE_W-1:0] pins_s;
   logic                     strobe_s;
   logic                     oe_n_s;
   logic                     shift_rise;
   logic [NUM_CH-1:0]        sreg;
   logic [NUM_CH-1:0]        latch_q;
   logic [NUM_CH-1:0]        fault_q;
   logic [NUM_CH-1:0]        drv_req;
   logic                     disabled;

   always_comb begin
      pins_raw            = '0;
      pins_raw[SB_SCLK]   = ser_clk_i;
      pins_raw[SB_DIN]    = ser_din_i;
      pins_raw[SB_STROBE] = strobe_i;
      pins_raw[SB_CLEAR]  = clear_i;
      pins_raw[SB_OEN]    = oe_n_i;
   end

   psd_sync #(
      .WIDTH   (SYNC_BUNDLE_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (pins_raw),
      .q_o (pins_s)
   );

   assign strobe_s = pins_s[SB_STROBE];
   assign oe_n_s   = pins_s[SB_OEN];

   psd_shift_latch #(
      .NUM_CH (NUM_CH)
   ) u_chain (
      .clk        (clk),
      .rst        (rst),
      .sclk_s     (pins_s[SB_SCLK]),
      .din_s      (pins_s[SB_DIN]),
      .clear_s    (pins_s[SB_CLEAR]),
      .strobe_s   (strobe_s),
      .shift_rise (shift_rise),
      .sreg       (sreg),
      .latch_q    (latch_q)
   );

   assign disabled = oe_n_s | uv_i;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      assign drv_req[i] = latch_q[i] & ~disabled & ~therm_i;

      psd_ocp_chan #(
         .FILT_CYCLES (FILT_CYCLES)
      ) u_ocp (
         .clk       (clk),
         .rst       (rst),
         .ocp_i     (ocp_i[i]),
         .drv_req   (drv_req[i]),
         .fault_clr (disabled),
         .fault_o   (fault_q[i])
      );

      assign drive_o[i] = drv_req[i] & ~fault_q[i];
   end

   assign ser_dout_o = sreg[NUM_CH-1];
   assign flag_n_o   = ~((|fault_q) | therm_i);

endmodule

// File: rtl/prot_sipo_driver_chk.sv
module prot_sipo_driver_chk #(
   parameter int unsigned NUM_CH = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [NUM_CH-1:0] ocp_i,
   input logic              therm_i,
   input logic              uv_i,
   input logic              ser_dout_o,
   input logic [NUM_CH-1:0] drive_o,
   input logic              flag_n_o,
   input logic [NUM_CH-1:0] sreg,
   input logic [NUM_CH-1:0] latch_q,
   input logic [NUM_CH-1:0] fault_q,
   input logic              disabled,
   input logic              shift_rise,
   input logic              strobe_s
);

   assert_shift_out_R1: assert property (@(posedge clk) disable iff (rst)
      shift_rise |=> (ser_dout_o == $past(sreg[NUM_CH-2])));

   assert_latch_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !strobe_s |=> $stable(latch_q));

   assert_fault_needs_ocp_R6: assert property (@(posedge clk) disable iff (rst)
      (|(fault_q & ~$past(fault_q))) |-> $past(|ocp_i));

   assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      !disabled |=> ((fault_q & $past(fault_q)) == $past(fault_q)));

   assert_thermal_off_R8: assert property (@(posedge clk) disable iff (rst)
      therm_i |-> (!flag_n_o && drive_o == '0));

   assert_uv_off_R9: assert property (@(posedge clk) disable iff (rst)
      uv_i |-> (drive_o == '0));

endmodule

bind prot_sipo_driver prot_sipo_driver_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .ocp_i      (ocp_i),
   .therm_i    (therm_i),
   .uv_i       (uv_i),
   .ser_dout_o (ser_dout_o),
   .drive_o    (drive_o),
   .flag_n_o   (flag_n_o),
   .sreg       (sreg),
   .latch_q    (latch_q),
   .fault_q    (fault_q),
   .disabled   (disabled),
   .shift_rise (shift_rise),
   .strobe_s   (strobe_s)
);

// File: tb/prot_sipo_driver_tb.sv
module prot_sipo_driver_tb;

   localparam int unsigned NCH  = 8;
   localparam int unsigned FILT = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ser_clk_i = 1'b0, ser_din_i = 1'b0, strobe_i = 1'b0, clear_i = 1'b0;
   logic oe_n_i = 1'b1, therm_i = 1'b0, uv_i = 1'b0;
   logic [NCH-1:0] ocp_i = '0;
   logic ser_dout_o, flag_n_o;
   logic [NCH-1:0] drive_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [NCH-1:0] model = '0;

   always #2 clk = ~clk;

   prot_sipo_driver #(.NUM_CH(NCH), .FILT_CYCLES(FILT), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst(rst), .ser_clk_i(ser_clk_i), .ser_din_i(ser_din_i),
      .strobe_i(strobe_i), .clear_i(clear_i), .oe_n_i(oe_n_i), .ocp_i(ocp_i),
      .therm_i(therm_i), .uv_i(uv_i), .ser_dout_o(ser_dout_o),
      .drive_o(drive_o), .flag_n_o(flag_n_o));

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic shift_bit(input logic b, input logic clr);
      ser_din_i = b;
      clear_i   = clr;
      tick(1);
      ser_clk_i = 1'b1;
      tick(4);
      ser_clk_i = 1'b0;
      tick(4);
      model = {model[NCH-2:0], clr ? 1'b0 : b};
   endtask

   task automatic load(input logic [NCH-1:0] p, input bit chk_out);
      for (int k = NCH - 1; k >= 0; k--) begin
         shift_bit(p[k], 1'b0);
         if (chk_out) check("R1 ser_dout", 32'(ser_dout_o), 32'(model[NCH-1]));
      end
   endtask

   task automatic strobe();
      strobe_i = 1'b1;
      tick(4);
      strobe_i = 1'b0;
      tick(4);
   endtask

   task automatic oe_pulse();
      oe_n_i = 1'b1;
      tick(4);
      oe_n_i = 1'b0;
      tick(4);
   endtask

   initial begin
      logic [NCH-1:0] prev;
      tick(4);
      rst = 1'b0;
      tick(1);
      check("R11 drive", 32'(drive_o), 32'h0);
      check("R11 flag", 32'(flag_n_o), 32'h1);
      check("R11 dout", 32'(ser_dout_o), 32'h0);
      oe_n_i = 1'b0;
      tick(4);

      // R1 and R3: sweep every pattern
      prev = '0;
      for (int p = 0; p < 256; p++) begin
         load(NCH'(p), 1'b1);
         check("R3 hold while strobe low", 32'(drive_o), 32'(prev));
         strobe();
         check("R3 latch copy", 32'(drive_o), 32'(p));
         check("R1 first bit at last stage", 32'(ser_dout_o), 32'((p >> 7) & 1));
         prev = NCH'(p);
      end

      // R2: clear shifts zeros
      load(8'hFF, 1'b0);
      strobe();
      for (int k = 0; k < NCH; k++) shift_bit(1'b1, 1'b1);
      clear_i = 1'b0;
      check("R2 not yet strobed", 32'(drive_o), 32'hFF);
      check("R2 dout zero", 32'(ser_dout_o), 32'h0);
      strobe();
      check("R2 cleared", 32'(drive_o), 32'h0);

      // R4: enable gating keeps contents
      load(8'hA5, 1'b0);
      strobe();
      oe_n_i = 1'b1;
      tick(4);
      check("R4 disabled", 32'(drive_o), 32'h0);
      oe_n_i = 1'b0;
      tick(4);
      check("R4 restored", 32'(drive_o), 32'hA5);

      // R8: thermal, not latched
      therm_i = 1'b1;
      tick(1);
      check("R8 off", 32'(drive_o), 32'h0);
      check("R8 flag low", 32'(flag_n_o), 32'h0);
      therm_i = 1'b0;
      tick(1);
      check("R8 recover drive", 32'(drive_o), 32'hA5);
      check("R8 recover flag", 32'(flag_n_o), 32'h1);

      // R5, R6, R7 on every channel
      load(8'hFF, 1'b0);
      strobe();
      for (int ch = 0; ch < NCH; ch++) begin
         ocp_i[ch] = 1'b1;
         tick(FILT - 1);
         ocp_i[ch] = 1'b0;
         check("R5 short pulse drive", 32'(drive_o), 32'hFF);
         check("R5 short pulse flag", 32'(flag_n_o), 32'h1);
         tick(1);
         ocp_i[ch] = 1'b1;
         tick(FILT - 1);
         ocp_i[ch] = 1'b0;
         check("R5 restart", 32'(drive_o), 32'hFF);
         tick(1);
         ocp_i[ch] = 1'b1;
         tick(FILT);
         ocp_i[ch] = 1'b0;
         check("R6 one channel off", 32'(drive_o), 32'(8'hFF & ~(8'h1 << ch)));
         check("R6 flag low", 32'(flag_n_o), 32'h0);
         tick(3);
         check("R7 latched drive", 32'(drive_o), 32'(8'hFF & ~(8'h1 << ch)));
         check("R7 latched flag", 32'(flag_n_o), 32'h0);
         oe_pulse();
         check("R7 cleared drive", 32'(drive_o), 32'hFF);
         check("R7 cleared flag", 32'(flag_n_o), 32'h1);
      end

      // R10: undriven channel never trips
      load(8'hFE, 1'b0);
      strobe();
      ocp_i[0] = 1'b1;
      tick(3 * FILT);
      check("R10 flag", 32'(flag_n_o), 32'h1);
      check("R10 drive", 32'(drive_o), 32'hFE);
      ocp_i[0] = 1'b0;

      // R9: undervoltage forces off and clears faults
      load(8'hFF, 1'b0);
      strobe();
      ocp_i[3] = 1'b1;
      tick(FILT);
      ocp_i[3] = 1'b0;
      check("R9 tripped first", 32'(flag_n_o), 32'h0);
      uv_i = 1'b1;
      tick(1);
      check("R9 off", 32'(drive_o), 32'h0);
      uv_i = 1'b0;
      tick(1);
      check("R9 fault cleared", 32'(drive_o), 32'hFF);
      check("R9 flag high", 32'(flag_n_o), 32'h1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule